// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Block Transfer Sequencer

This block drives a small serial EEPROM with 16-bit words from a fast system clock. It generates the chip select, the serial clock and the serial command/data line itself, and it samples the device's reply line. A single request names a start address, a word count and a direction. The sequencer then runs one complete command cycle per word and steps the address by one after each word. Chip select drops for one serial clock between command cycles.

A read cycle sends a preamble clock, then the read opcode and the address. It then clocks in seventeen reply bits. The first reply bit is a dummy zero and is discarded. The other sixteen are returned on `rdata` with a one-cycle `rd_valid` strobe. A write request is framed by a write-enable command at the start and a write-disable command at the end. Each word in between is sent with the write opcode and its address. The sequencer then polls the device's ready indication, and a poll that lasts too long sets an error flag. The serial clock's low and high phases each last a parameterised number of system cycles. This sets the minimum timing the device needs.

Top module: `mw_eeprom_seq`

## Requirements
- R1: After reset and whenever idle, `mem_cs`, `mem_sck`, `mem_sout`, `busy`, `done`, `rd_valid` and `wr_take` are low.
- R2: Every serial clock low phase inside a request lasts exactly SK_LO_CYC system cycles and every high phase exactly SK_HI_CYC cycles. `mem_sout` changes only while `mem_sck` is low.
- R3: Each read word is sent as one serial clock with chip select high and `mem_sout` low, then the bits 1,1,0, then the address MSB first, then 17 clocks with `mem_sout` low. `mem_sin` is sampled at the end of each high phase. The first sample is dropped and the remaining 16 appear MSB first on `rdata` with a one-cycle `rd_valid` pulse.
- R4: A request of N words addresses start_addr, start_addr+1, … modulo 2^ADDR_W. After each command the sequencer runs exactly one serial clock with chip select low.
- R5: A write request begins with the write-enable command: the preamble clock, then 1,0,0,1,1 and zeros up to a total of 3+ADDR_W bits (9 for ADDR_W=6), then one chip-select-low clock.
- R6: Each write word is sent as the preamble clock, then 1,0,1, then the address MSB first, then the 16 data bits MSB first. `wr_take` pulses once for each word that is taken from `wdata`.
- R7: After the data bits, chip select stays low for one clock. It then goes high and the serial clock keeps running until `mem_sin` is sampled high. One chip-select-low clock follows.
- R8: After the last word, the write-disable command is sent: the preamble clock, then 1,0,0,0,0 and zeros up to 3+ADDR_W bits, then one chip-select-low clock. Only then does `done` pulse.
- R9: If `mem_sin` stays low for POLL_LIMIT poll clocks, `timeout_err` is set and the remaining words are skipped. The write-disable command is still sent. The flag clears when the next request starts.
- R10: `busy` is high from the cycle after an accepted `start` until the request ends. `done` is a single-cycle pulse in the cycle `busy` falls. A `start` while busy, or with `word_cnt` of 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| wr_mode | input | 1 | 1 = block write, 0 = block read |
| start_addr | input | ADDR_W | First word address |
| word_cnt | input | ADDR_W+1 | Number of words, 1 to 2^ADDR_W |
| wdata | input | 16 | Word to write; advance after each `wr_take` |
| wr_take | output | 1 | Pulse: current `wdata` has been captured |
| rdata | output | 16 | Last word read |
| rd_valid | output | 1 | Pulse: `rdata` holds a new word |
| busy | output | 1 | Request in progress |
| done | output | 1 | Pulse at the end of a request |
| timeout_err | output | 1 | Ready polling exceeded POLL_LIMIT clocks |
| mem_cs | output | 1 | Device chip select |
| mem_sck | output | 1 | Device serial clock |
| mem_sout | output | 1 | Serial command and data line to the device |
| mem_sin | input | 1 | Serial reply line from the device |

## Verification
A bit counter or shift register that slips by one position shows up on the very next command. The device model then decodes a wrong opcode or address. Read data comes back off by one bit, or a write lands at the wrong word, which a readback catches. A wrong frame-type or remaining-word state shows up at the end of the request. The number of chip-select-low clocks would differ, the write-enable would be left set in the model, or `done` would arrive early or never. A divider fault violates the phase lengths on the first serial clock of any request.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_PRE, S_SHIFT, S_RDATA, S_GAP, S_POLL, S_RST
   } seq_st_t;

   typedef enum logic [1:0] {
      F_ENA, F_WORD, F_DIS
   } frame_t;
endpackage

// File: rtl/mw_sk_timer.sv
module mw_sk_timer #(
   parameter int LO_CYC = 13,
   parameter int HI_CYC = 38
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sk,
   output logic slot_end
);
   localparam int PER = LO_CYC + HI_CYC;
   localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en)             cnt_q <= '0;
      else if (cnt_q == CW'(PER - 1)) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

   assign sk       = en && (cnt_q >= CW'(LO_CYC));
   assign slot_end = en && (cnt_q == CW'(PER - 1));
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] word
);
   always_ff @(posedge clk) begin
      if (!rst_n)     word <= '0;
      else if (shift) word <= {word[W-2:0], bit_in};
   end
endmodule

// File: rtl/mw_eeprom_seq.sv
module mw_eeprom_seq
   import mw_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int SK_LO_CYC  = 13,
   parameter int SK_HI_CYC  = 38,
   parameter int POLL_LIMIT = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_mode,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W:0]   word_cnt,
   input  logic [15:0]       wdata,
   output logic              wr_take,
   output logic [15:0]       rdata,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic              mem_cs,
   output logic              mem_sck,
   output logic              mem_sout,
   input  logic              mem_sin
);
   localparam int DW     = 16;
   localparam int CMD_W  = 3 + ADDR_W;
   localparam int FW     = CMD_W + DW;
   localparam int BW     = $clog2(FW + 1);
   localparam int PW     = $clog2(POLL_LIMIT + 1);
   localparam int RD_CLK = DW + 1;
   localparam logic [FW-1:0] ENA_V = {5'b10011, {(FW-5){1'b0}}};
   localparam logic [FW-1:0] DIS_V = {5'b10000, {(FW-5){1'b0}}};
   localparam logic [ADDR_W-1:0] A_ONE = 1;
   localparam logic [ADDR_W:0]   L_ONE = 1;

   if (ADDR_W != 6 && ADDR_W != 8) begin : g_bad_aw
      $error("mw_eeprom_seq: ADDR_W must be 6 or 8");
   end
   if (SK_LO_CYC < 1 || SK_HI_CYC < 1) begin : g_bad_sk
      $error("mw_eeprom_seq: serial clock phases need at least one cycle");
   end
   if (POLL_LIMIT < 1) begin : g_bad_poll
      $error("mw_eeprom_seq: POLL_LIMIT must be positive");
   end

   function automatic logic [FW-1:0] word_frame(input logic wr,
                                                input logic [ADDR_W-1:0] a,
                                                input logic [DW-1:0] d);
      return {(wr ? 3'b101 : 3'b110), a, (wr ? d : {DW{1'b0}})};
   endfunction

   seq_st_t             st_q;
   frame_t              frm_q;
   logic                wr_q, err_q, done_q, rdv_q, take_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [ADDR_W:0]     left_q;
   logic [FW-1:0]       sh_q;
   logic [BW-1:0]       bcnt_q;
   logic [4:0]          rcnt_q;
   logic [PW-1:0]       pcnt_q;
   logic                slot_end, sk_w;

   mw_sk_timer #(.LO_CYC(SK_LO_CYC), .HI_CYC(SK_HI_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(st_q != S_IDLE),
      .sk(sk_w), .slot_end(slot_end)
   );

   mw_rx_shift #(.W(DW)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .shift(slot_end && st_q == S_RDATA),
      .bit_in(mem_sin), .word(rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;  frm_q  <= F_WORD;
         wr_q   <= 1'b0;    err_q  <= 1'b0;
         done_q <= 1'b0;    rdv_q  <= 1'b0;   take_q <= 1'b0;
         addr_q <= '0;      left_q <= '0;     sh_q   <= '0;
         bcnt_q <= '0;      rcnt_q <= '0;     pcnt_q <= '0;
      end else begin
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         take_q <= 1'b0;
         if (st_q == S_IDLE) begin
            if (start && word_cnt != '0) begin
               wr_q   <= wr_mode;
               addr_q <= start_addr;
               left_q <= word_cnt;
               err_q  <= 1'b0;
               bcnt_q <= BW'(CMD_W);
               st_q   <= S_PRE;
               if (wr_mode) begin
                  frm_q <= F_ENA;
                  sh_q  <= ENA_V;
               end else begin
                  frm_q <= F_WORD;
                  sh_q  <= word_frame(1'b0, start_addr, wdata);
               end
            end
         end else if (slot_end) begin
            case (st_q)
               S_PRE: st_q <= S_SHIFT;
               S_SHIFT: begin
                  sh_q   <= sh_q << 1;
                  bcnt_q <= bcnt_q - 1'b1;
                  rcnt_q <= 5'(RD_CLK);
                  if (bcnt_q == BW'(1)) begin
                     if (frm_q != F_WORD) st_q <= S_RST;
                     else if (wr_q)       st_q <= S_GAP;
                     else                 st_q <= S_RDATA;
                  end
               end
               S_RDATA: begin
                  rcnt_q <= rcnt_q - 1'b1;
                  if (rcnt_q == 5'd1) begin
                     rdv_q <= 1'b1;
                     st_q  <= S_RST;
                  end
               end
               S_GAP: begin
                  pcnt_q <= '0;
                  st_q   <= S_POLL;
               end
               S_POLL: begin
                  if (mem_sin) st_q <= S_RST;
                  else if (pcnt_q == PW'(POLL_LIMIT - 1)) begin
                     err_q <= 1'b1;
                     st_q  <= S_RST;
                  end else pcnt_q <= pcnt_q + 1'b1;
               end
               S_RST: begin
                  case (frm_q)
                     F_ENA: begin
                        frm_q  <= F_WORD;
                        sh_q   <= word_frame(1'b1, addr_q, wdata);
                        bcnt_q <= BW'(FW);
                        take_q <= 1'b1;
                        st_q   <= S_PRE;
                     end
                     F_WORD: begin
                        addr_q <= addr_q + A_ONE;
                        left_q <= left_q - L_ONE;
                        if (left_q > L_ONE && !err_q) begin
                           sh_q   <= word_frame(wr_q, addr_q + A_ONE, wdata);
                           bcnt_q <= wr_q ? BW'(FW) : BW'(CMD_W);
                           take_q <= wr_q;
                           st_q   <= S_PRE;
                        end else if (wr_q) begin
                           frm_q  <= F_DIS;
                           sh_q   <= DIS_V;
                           bcnt_q <= BW'(CMD_W);
                           st_q   <= S_PRE;
                        end else begin
                           done_q <= 1'b1;
                           st_q   <= S_IDLE;
                        end
                     end
                     default: begin
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                     end
                  endcase
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   assign mem_cs      = (st_q == S_PRE) || (st_q == S_SHIFT) ||
                        (st_q == S_RDATA) || (st_q == S_POLL);
   assign mem_sout    = (st_q == S_SHIFT) && sh_q[FW-1];
   assign mem_sck     = sk_w;
   assign busy        = (st_q != S_IDLE);
   assign done        = done_q;
   assign rd_valid    = rdv_q;
   assign wr_take     = take_q;
   assign timeout_err = err_q;
endmodule

// File: rtl/mw_eeprom_seq_chk.sv
module mw_eeprom_seq_chk #(
   parameter int SK_LO_CYC = 13,
   parameter int SK_HI_CYC = 38
) (
   input logic clk,
   input logic rst_n,
   input logic mem_cs,
   input logic mem_sck,
   input logic mem_sout,
   input logic busy,
   input logic done,
   input logic rd_valid,
   input logic wr_take
);
   logic [15:0] hi_run, lo_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= mem_sck ? hi_run + 1'b1 : '0;
         lo_run <= (!mem_sck && busy) ? lo_run + 1'b1 : '0;
      end
   end

   p_sk_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_sck) |-> hi_run == 16'(SK_HI_CYC));
   p_sk_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_sck) |-> lo_run == 16'(SK_LO_CYC));
   p_sout_when_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_sout) |-> !mem_sck);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_cs && !mem_sck && !mem_sout));
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_busy_fall_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_take));
endmodule

bind mw_eeprom_seq mw_eeprom_seq_chk #(
   .SK_LO_CYC(SK_LO_CYC), .SK_HI_CYC(SK_HI_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_cs(mem_cs), .mem_sck(mem_sck),
   .mem_sout(mem_sout), .busy(busy), .done(done),
   .rd_valid(rd_valid), .wr_take(wr_take)
);

// File: tb/mw_eeprom_seq_test.sv
module mw_eeprom_seq_test;
   localparam int A  = 6;
   localparam int LO = 2;
   localparam int HI = 3;
   localparam int PL = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, wr_mode = 1'b0;
   logic [A-1:0] start_addr = '0;
   logic [A:0]   word_cnt = '0;
   logic [15:0]  wdata = '0;
   logic wr_take, rd_valid, busy, done, timeout_err;
   logic [15:0] rdata;
   logic mem_cs, mem_sck, mem_sout;
   logic mem_sin = 1'b0;

   always #10 clk = ~clk;

   mw_eeprom_seq #(.ADDR_W(A), .SK_LO_CYC(LO), .SK_HI_CYC(HI),
                   .POLL_LIMIT(PL)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
      .start_addr(start_addr), .word_cnt(word_cnt), .wdata(wdata),
      .wr_take(wr_take), .rdata(rdata), .rd_valid(rd_valid),
      .busy(busy), .done(done), .timeout_err(timeout_err),
      .mem_cs(mem_cs), .mem_sck(mem_sck), .mem_sout(mem_sout),
      .mem_sin(mem_sin)
   );

   int checks = 0, fails = 0;
   logic [15:0] mem [64];
   logic [15:0] rbuf [8];
   logic [15:0] wbuf [8];
   int rn, tk, dn, widx;
   int rst_slots, pre_err, ctl_bad, blocked, dly;
   bit we, pend;
   int n, pc;
   logic [31:0] sr;
   logic [2:0]  op;
   logic [A-1:0] fa;
   int hr, lr, hi_bad, lo_bad, sout_bad;
   logic psck, psout;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Device model: decodes frames at rising serial clock edges.
   always @(posedge mem_sck) begin
      if (!mem_cs) begin
         rst_slots++;
         if (n > 0 && op == 3'b100 && n != 4 + A) ctl_bad++;
         if (pend && pc > 0) pend = 0;
         n = 0; op = 3'b000; mem_sin = 1'b0;
      end else if (pend) begin
         if (pc >= dly) begin mem_sin = 1'b1; pend = 0; end
         else begin mem_sin = 1'b0; pc++; end
      end else begin
         n++;
         sr = {sr[30:0], mem_sout};
         if (n == 1 && mem_sout) pre_err++;
         if (n == 4) op = sr[2:0];
         if (n == 4 + A) begin
            fa = sr[A-1:0];
            if (op == 3'b100 && fa[A-1:A-2] == 2'b11) we = 1;
            if (op == 3'b100 && fa[A-1:A-2] == 2'b00) we = 0;
         end
         if (op == 3'b110 && n > 4 + A && n <= 4 + A + 17)
            mem_sin = (n == 5 + A) ? 1'b0 : mem[fa][17 - (n - 4 - A)];
         if (op == 3'b101 && n == 4 + A + 16) begin
            if (we) mem[fa] = sr[15:0]; else blocked++;
            pend = 1; pc = 0;
         end
      end
   end

   // Port monitor sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin if (rn < 8) rbuf[rn] = rdata; rn++; end
         if (wr_take) begin tk++; widx++; wdata = wbuf[widx % 8]; end
         if (done) dn++;
         if (mem_sck && !psck) begin
            if (busy && lr != LO) lo_bad++;
            hr = 1;
         end else if (mem_sck) hr++;
         else if (psck) begin
            if (hr != HI) hi_bad++;
            lr = 1;
         end else lr = busy ? lr + 1 : 0;
         if (mem_sout != psout && mem_sck) sout_bad++;
      end
      psck = mem_sck;
      psout = mem_sout;
   end

   task automatic clear_stats();
      rn = 0; tk = 0; dn = 0; widx = 0; rst_slots = 0;
      pre_err = 0; ctl_bad = 0; blocked = 0;
   endtask

   task automatic kick(input bit wr, input int addr, input int cnt);
      @(negedge clk);
      start = 1'b1; wr_mode = wr; start_addr = A'(addr); word_cnt = (A+1)'(cnt);
      wdata = wbuf[0];
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (dn == 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!mem_cs && !mem_sck && !mem_sout, "R1 pins idle", {mem_cs, mem_sck, mem_sout}, 0);
      chk(!busy && !done && !rd_valid && !wr_take, "R1 status idle",
          {busy, done, rd_valid, wr_take}, 0);
   endtask

   task automatic t_read(input int addr, input int cnt);
      logic [15:0] pat [4];
      pat[0] = 16'hA5C3; pat[1] = 16'hFFFF; pat[2] = 16'h0000; pat[3] = 16'h8001;
      for (int i = 0; i < cnt; i++) mem[(addr + i) % 64] = pat[i % 4] ^ 16'(addr);
      clear_stats();
      kick(1'b0, addr, cnt);
      wait_done();
      chk(rn == cnt, "R3 word count", rn, cnt);
      for (int i = 0; i < cnt; i++)
         chk(rbuf[i] == mem[(addr + i) % 64], "R3/R4 read data", rbuf[i], mem[(addr + i) % 64]);
      chk(rst_slots == cnt, "R4 cs-low clocks", rst_slots, cnt);
      chk(pre_err == 0, "R3 preamble low", pre_err, 0);
      chk(dn == 1 && !busy, "R10 single done", dn, 1);
      chk(!timeout_err, "R9 error cleared by new start", timeout_err, 0);
   endtask

   task automatic t_write(input int addr, input int cnt, input int d);
      for (int i = 0; i < 8; i++) wbuf[i] = 16'h1357 * 16'(i + 3) ^ 16'(addr);
      dly = d;
      clear_stats();
      kick(1'b1, addr, cnt);
      wait_done();
      for (int i = 0; i < cnt; i++)
         chk(mem[(addr + i) % 64] == wbuf[i], "R6 written word", mem[(addr + i) % 64], wbuf[i]);
      chk(tk == cnt, "R6 take pulses", tk, cnt);
      chk(blocked == 0 && ctl_bad == 0, "R5 enable frame", blocked + ctl_bad, 0);
      chk(!we, "R8 disabled at end", we, 0);
      chk(rst_slots == 2 * cnt + 2, "R7 cs-low clocks", rst_slots, 2 * cnt + 2);
      chk(!timeout_err, "R9 no timeout", timeout_err, 0);
   endtask

   task automatic t_timeout();
      mem[11] = 16'h1111; mem[12] = 16'h2222;
      for (int i = 0; i < 8; i++) wbuf[i] = 16'hBEE0 + 16'(i);
      dly = 50;
      clear_stats();
      kick(1'b1, 10, 3);
      wait_done();
      chk(timeout_err, "R9 timeout flag", timeout_err, 1);
      chk(mem[10] == wbuf[0], "R9 first word kept", mem[10], wbuf[0]);
      chk(mem[11] == 16'h1111, "R9 later words skipped", mem[11], 16'h1111);
      chk(tk == 1, "R9 one word taken", tk, 1);
      chk(!we, "R8 disable after timeout", we, 0);
      chk(rst_slots == 4, "R9 cs-low clocks", rst_slots, 4);
   endtask

   task automatic t_ignore();
      clear_stats();
      kick(1'b0, 3, 0);
      repeat (20) @(negedge clk);
      chk(!busy && dn == 0, "R10 zero count ignored", busy, 0);
      mem[5] = 16'h6C39;
      clear_stats();
      kick(1'b0, 5, 1);
      repeat (30) @(negedge clk);
      kick(1'b1, 20, 2);
      wait_done();
      chk(rn == 1 && rbuf[0] == 16'h6C39, "R10 start while busy ignored", rbuf[0], 16'h6C39);
      chk(tk == 0 && rst_slots == 1, "R10 no second request", tk + rst_slots, 1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      n = 0; pc = 0; we = 0; pend = 0; sr = '0; op = '0; fa = '0; dly = 1;
      hr = 0; lr = 0; hi_bad = 0; lo_bad = 0; sout_bad = 0; psck = 0; psout = 0;
      for (int i = 0; i < 64; i++) mem[i] = 16'(i * 257);
      for (int i = 0; i < 8; i++) wbuf[i] = '0;
      clear_stats();
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_read(7, 1);
      t_read(62, 3);
      t_write(30, 2, 2);
      t_write(62, 3, 0);
      t_read(30, 2);
      t_timeout();
      t_read(40, 4);
      t_ignore();
      chk(hi_bad == 0, "R2 high phase length", hi_bad, 0);
      chk(lo_bad == 0, "R2 low phase length", lo_bad, 0);
      chk(sout_bad == 0, "R2 sout moves with sck low", sout_bad, 0);
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
   end
endmodule